// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the completion pulses of up to 32 DMA channels into one level-sensitive interrupt line. Every channel owns one bit in each of three 32-bit registers: a sticky raw status word, an enable mask, and a read-only pending word. The pending word is the status word ANDed with the mask. Software reaches all three through a simple register port that has read and write strobes, an address and write data. Read data returns one cycle after the read strobe.

A channel reports completion with a one-cycle pulse on its `done_i` bit. That pulse sets the channel's status bit, and the bit stays set until software writes a one to it. When any pending bit is set, the interrupt is raised. Software can mask the line completely by clearing the enable word and can still poll the raw status. It then acknowledges each channel on its own by writing ones to the status word.

Top module: `dmairq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, status and enable are all zeros, `irq_o` is low and `reg_rdata` reads zero.
- R2: A one-cycle pulse on `done_i[i]` sets bit i of the status register (offset 0x080000) at the next clock edge. Several channels may pulse in the same cycle.
- R3: A write to the status offset clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: Writing 0xFFFFFFFF to the status offset clears all status bits in one cycle.
- R5: When `done_i[i]` pulses in the same cycle as a write that clears bit i, bit i ends up set.
- R6: The enable register (offset 0x080008) reads back the last value written to it. Status bits are set and are readable whatever the enable value.
- R7: The pending register (offset 0x080004) reads as status AND enable, and writes to it change neither register.
- R8: `irq_o` is high exactly when some bit of status AND enable is 1. It follows the register state in the same cycle the state changes. Writing 0 to enable therefore drops it while status bits stay set.
- R9: The read data is registered: it reflects the addressed register as of the clock edge on which `reg_rd` is sampled and holds while `reg_rd` is low. Addresses other than the three offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | N_CH | Per-channel one-cycle completion pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, any masked channel pending |

## Verification
A status bit that is lost or stuck shows up at the ports on the next status or pending read, which is one cycle after the read strobe. If it belongs to an enabled channel, it also shows on `irq_o` in the cycle after the faulty edge. A corrupted mask shows as a wrong enable readback and as `irq_o` rising or failing to rise while the status is unchanged. The stimulus therefore follows every set, clear, collision and mask change with both an immediate `irq_o` sample and readbacks of all three offsets.

// File: rtl/dmairq_pkg.sv
// Package: shared widths and register offsets of the DMA interrupt aggregator.
// Assumes byte addresses; the offsets are fixed by the software map.
package dmairq_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam logic [31:0] OFF_STATUS = 32'h0008_0000;
    localparam logic [31:0] OFF_PEND   = 32'h0008_0004;
    localparam logic [31:0] OFF_ENABLE = 32'h0008_0008;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_PEND   = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dmairq_status.sv
// Module: sticky per-channel completion status.
// A set pulse wins over a write-one-to-clear of the same bit.
// Assumes set_i pulses last one cycle; clr_i is already qualified by decode.
module dmairq_status #(
    parameter int unsigned N_CH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_i,
    input  logic [N_CH-1:0] clr_i,
    output logic [N_CH-1:0] status_o
);
    logic [N_CH-1:0] st_q;

    // Update status: clear the requested bits first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_i) | set_i;
    end

    assign status_o = st_q;

    // R2 and R5: every pulsed bit is set after the edge, even if it was cleared.
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R3: a cleared bit that saw no pulse reads zero afterwards.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

    // R3: bits neither pulsed nor cleared keep their value.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((status_o ^ $past(status_o)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/dmairq_mask.sv
// Module: per-channel interrupt enable register.
// Assumes wr_i is already qualified by the address decode.
module dmairq_mask #(
    parameter int unsigned N_CH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [N_CH-1:0] wdata_i,
    output logic [N_CH-1:0] enable_o
);
    logic [N_CH-1:0] en_q;

    // Load the mask on a decoded write, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i;
    end

    assign enable_o = en_q;

    // R6: a write is visible on the register after the edge.
    p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (enable_o == $past(wdata_i)));

    // R6: without a write the mask is stable.
    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && $past(rst_n)) |=> $stable(enable_o));
endmodule

// File: rtl/dmairq_readback.sv
// Module: registered read multiplexer for the three registers.
// Assumes sel_i is decoded from the address in the same cycle as rd_i.
// Unmapped addresses return zero, and the data holds between reads.
module dmairq_readback
    import dmairq_pkg::*;
#(
    parameter int unsigned N_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  reg_sel_e          sel_i,
    input  logic [N_CH-1:0]   status_i,
    input  logic [N_CH-1:0]   pend_i,
    input  logic [N_CH-1:0]   enable_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [N_CH-1:0]   mux_val;
    logic [DATA_W-1:0] rdata_q;

    // Select the addressed register.
    always_comb begin
        unique case (sel_i)
            SEL_STATUS: mux_val = status_i;
            SEL_PEND:   mux_val = pend_i;
            SEL_ENABLE: mux_val = enable_i;
            default:    mux_val = '0;
        endcase
    end

    // Capture read data on a read strobe, zero-extended to the bus width.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= DATA_W'(mux_val);
    end

    assign rdata_o = rdata_q;

    // R9: read data holds while no read is issued.
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && $past(rst_n)) |=> $stable(rdata_o));

    // R9: an unmapped read returns zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i == SEL_NONE) |=> (rdata_o == '0));
endmodule

// File: rtl/dmairq_ctrl.sv
// Module: top of the DMA completion interrupt aggregator.
// Decodes the register port, keeps status and mask, forms the pending word
// and drives a level interrupt from it.
// Assumes at most one of reg_wr/reg_rd is relevant per offset per cycle.
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int unsigned N_CH   = 32,
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   done_i,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);

    reg_sel_e        sel;
    logic [N_CH-1:0] clr_vec;
    logic            en_wr;
    logic [N_CH-1:0] status;
    logic [N_CH-1:0] enable;
    logic [N_CH-1:0] pending;

    // Decode the address into a register select.
    always_comb begin
        if      (reg_addr == A_STATUS) sel = SEL_STATUS;
        else if (reg_addr == A_PEND)   sel = SEL_PEND;
        else if (reg_addr == A_ENABLE) sel = SEL_ENABLE;
        else                           sel = SEL_NONE;
    end

    // Form the write strobes; writes to the pending offset go nowhere.
    always_comb begin
        clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata[N_CH-1:0] : '0;
        en_wr   = reg_wr && sel == SEL_ENABLE;
    end

    dmairq_status #(.N_CH(N_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (done_i),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    dmairq_mask #(.N_CH(N_CH)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (en_wr),
        .wdata_i  (reg_wdata[N_CH-1:0]),
        .enable_o (enable)
    );

    // Pending view and interrupt level.
    always_comb begin
        pending = status & enable;
        irq_o   = |pending;
    end

    dmairq_readback #(.N_CH(N_CH)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (reg_rd),
        .sel_i    (sel),
        .status_i (status),
        .pend_i   (pending),
        .enable_i (enable),
        .rdata_o  (reg_rdata)
    );

    // R8: a fully masked aggregator never interrupts.
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq_o);

    // R8: an empty status word never interrupts.
    p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq_o);

    // R7: a write to the pending offset leaves the mask untouched.
    p_pend_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_PEND) |=> $stable(enable));
endmodule

// File: tb/tb_dmairq_ctrl.sv
module tb_dmairq_ctrl;
    localparam int    CLK_P  = 10;
    localparam int    N_CH   = 32;
    localparam int    ADDR_W = 20;
    localparam logic [ADDR_W-1:0] A_ST  = 20'h80000;
    localparam logic [ADDR_W-1:0] A_PD  = 20'h80004;
    localparam logic [ADDR_W-1:0] A_EN  = 20'h80008;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CH-1:0]   done_i = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    dmairq_ctrl #(.N_CH(N_CH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Monitor: note captured reads, compare at the following falling edge.
    always @(posedge clk) rd_seen <= reg_rd & rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] d);
        @(negedge clk);
        done_i = d;
        @(negedge clk);
        done_i = '0;
    endtask

    // Sample irq at a falling edge, after all register updates have settled.
    task automatic chk_irq(input logic e, input string t);
        n_cmp++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P*20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1");
        n_cmp++;
        if (reg_rdata !== 32'h0) begin n_bad++; $display("FAIL R1: rdata actual %h expected 0", reg_rdata); end
        rd(A_ST, 32'h0, "R1");
        rd(A_EN, 32'h0, "R1");
        rd(A_PD, 32'h0, "R1");

        // R2 set by pulses, masked: no irq
        pulse(32'h8000_0008);
        chk_irq(1'b0, "R8");
        rd(A_ST, 32'h8000_0008, "R2");
        rd(A_PD, 32'h0, "R7");
        pulse(32'h0F0F_0000);
        rd(A_ST, 32'h8F0F_0008, "R2");

        // R6 enable readback, R8 irq rises
        wr(A_EN, 32'h0000_0008);
        chk_irq(1'b1, "R8");
        rd(A_EN, 32'h0000_0008, "R6");
        rd(A_ST, 32'h8F0F_0008, "R6");
        rd(A_PD, 32'h0000_0008, "R7");

        // R7 writes to pending ignored
        wr(A_PD, 32'hFFFF_FFFF);
        rd(A_PD, 32'h0000_0008, "R7");
        rd(A_EN, 32'h0000_0008, "R7");
        rd(A_ST, 32'h8F0F_0008, "R7");

        // R8 mask all: irq drops, status kept
        wr(A_EN, 32'h0);
        chk_irq(1'b0, "R8");
        rd(A_ST, 32'h8F0F_0008, "R8");

        // R3 clear selected bit, zero write keeps
        wr(A_ST, 32'h0000_0008);
        rd(A_ST, 32'h8F0F_0000, "R3");
        wr(A_ST, 32'h0);
        rd(A_ST, 32'h8F0F_0000, "R3");
        wr(A_ST, 32'h0F00_0000);
        rd(A_ST, 32'h800F_0000, "R3");

        // R5 set beats simultaneous clear
        @(negedge clk);
        done_i = 32'h0000_0020; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h8000_0020;
        @(negedge clk);
        done_i = '0; reg_wr = 1'b0;
        rd(A_ST, 32'h000F_0020, "R5");

        // R4 clear all
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, 32'h0, "R4");

        // R8 irq rises in the cycle after an enabled pulse
        wr(A_EN, 32'h0000_0100);
        chk_irq(1'b0, "R8");
        pulse(32'h0000_0200);
        chk_irq(1'b0, "R8");
        @(negedge clk);
        done_i = 32'h0000_0100;
        @(negedge clk);
        done_i = '0;
        chk_irq(1'b1, "R8");
        wr(A_ST, 32'h0000_0100);
        chk_irq(1'b0, "R8");
        rd(A_ST, 32'h0000_0200, "R3");

        // R9 unmapped reads and hold
        rd(20'h80010, 32'h0, "R9");
        rd(20'h00000, 32'h0, "R9");
        rd(A_EN, 32'h0000_0100, "R9");
        repeat (3) @(negedge clk);
        n_cmp++;
        if (reg_rdata !== 32'h0000_0100) begin n_bad++; $display("FAIL R9: held rdata actual %h expected 00000100", reg_rdata); end

        repeat (2) @(negedge clk);
        summary();
    end
endmodule